// File: doc/BRIEF.md
# Triggered Delay-Width Pulse Generator

This peripheral timer waits for a rising edge on an asynchronous trigger input. Then it counts a programmable number of time-base ticks before it drives a single output pulse, and it holds that pulse for a second programmable number of ticks. The time base is a configuration choice. It can be a one-clock-cycle tick strobe that arrives already in the system clock domain, or the rising edges of an asynchronous external clock input.

One interrupt line is raised for one cycle. A control field chooses the event that drives it: the accepted trigger, the rising edge of the output, or the falling edge of the output. The field can also turn the interrupt off. Software programs delay, width and control through a simple write port and can read them back through a registered read port. Address decoding for the host lives outside this block.

Top module: `pdg_top`

## Requirements
- R1: During and after a synchronous reset, pulse_out and irq are 0 and all three registers read back as 0. A reset asserted in the middle of a pulse drops pulse_out at the next clock edge.
- R2: A write with wr_en high stores wr_data at the edge. Address 0 holds the delay, address 1 the width, and address 2 the control (bit 0 selects the time base, bits 2:1 select the interrupt source). Read data appears on rd_data one clock edge after rd_addr is presented. Unused control bits and address 3 read as 0.
- R3: A trigger_in rise presented just after a clock edge is accepted at the third clock edge that follows, through a two-flop synchroniser and an edge detector. With the trigger interrupt source selected, irq is high in the cycle after that third edge and not before.
- R4: For a delay D, pulse_out rises on the (D+1)th selected time-base tick after the trigger is accepted. The delay register is captured when the trigger is accepted.
- R5: For a width W greater than 0, pulse_out stays high for exactly W ticks and falls on tick D+1+W. The width register is captured when the pulse starts.
- R6: With a width of 0, pulse_out never goes high, no rising-edge or falling-edge interrupt is produced, and the block becomes idle again after D+1 ticks.
- R7: With control bit 0 clear, the time base is usec_tick, taken directly with one count per high cycle. With it set, the time base is each rising edge of ext_tb_in after the two-flop synchroniser. The unselected source has no effect on timing.
- R8: The interrupt source field works as follows: 00 is the accepted trigger, 01 is the output rising edge, 10 is the output falling edge, and 11 is no interrupt. irq is a one-cycle pulse that is registered on the same clock edge as the event.
- R9: A trigger rise that arrives while a delay or a pulse is in progress is ignored and does not change the timing of the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Registered read data |
| usec_tick | input | 1 | Internal time-base strobe, one cycle wide, in clk domain |
| trig_in | input | 1 | Asynchronous trigger input, rising edge starts a run |
| ext_tb_in | input | 1 | Asynchronous external time base, counted on rising edges |
| pulse_out | output | 1 | Registered output pulse |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest case to reach is a fresh trigger edge that arrives while a run is still counting. It has to land inside the delay window in one case and inside the output pulse in another, and the run's timing must come out unchanged. The stimulus places it there by counting time-base ticks itself: it raises the trigger just before a chosen tick of the run and lowers it after that tick. Each tick is also interleaved with pulses on the time base that is not selected. An edge counted from the wrong source therefore moves the measured rise and fall positions.

// File: rtl/pdg_pkg.sv
package pdg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_PULSE = 2'd2
  } pdg_state_e;

  typedef enum logic [1:0] {
    IRQ_TRIG = 2'd0,
    IRQ_RISE = 2'd1,
    IRQ_FALL = 2'd2,
    IRQ_NONE = 2'd3
  } pdg_irq_src_e;

  localparam int unsigned ADDR_DELAY = 0;
  localparam int unsigned ADDR_WIDTH = 1;
  localparam int unsigned ADDR_CTRL  = 2;

  localparam int unsigned CTRL_TB_BIT  = 0;
  localparam int unsigned CTRL_SRC_LSB = 1;
  localparam int unsigned CTRL_BITS    = 3;

endpackage

// File: rtl/pdg_sync_edge.sv
module pdg_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain_q[STAGES-1];
  end

  assign rise = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/pdg_regs.sv
module pdg_regs
  import pdg_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic [CNT_W-1:0]  delay_val,
  output logic [CNT_W-1:0]  width_val,
  output logic              tb_ext,
  output pdg_irq_src_e      irq_src
);
  logic [CNT_W-1:0] delay_q, width_q;
  logic             tb_q;
  pdg_irq_src_e     src_q;
  logic [CNT_W-1:0] ctrl_view;

  always_ff @(posedge clk) begin
    if (rst) begin
      delay_q <= '0;
      width_q <= '0;
      tb_q    <= 1'b0;
      src_q   <= IRQ_TRIG;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(ADDR_DELAY)) delay_q <= wr_data;
      if (wr_addr == ADDR_W'(ADDR_WIDTH)) width_q <= wr_data;
      if (wr_addr == ADDR_W'(ADDR_CTRL)) begin
        tb_q  <= wr_data[CTRL_TB_BIT];
        src_q <= pdg_irq_src_e'(wr_data[CTRL_SRC_LSB +: 2]);
      end
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTRL_TB_BIT] = tb_q;
    ctrl_view[CTRL_SRC_LSB +: 2] = src_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      if (rd_addr == ADDR_W'(ADDR_DELAY))      rd_data <= delay_q;
      else if (rd_addr == ADDR_W'(ADDR_WIDTH)) rd_data <= width_q;
      else if (rd_addr == ADDR_W'(ADDR_CTRL))  rd_data <= ctrl_view;
      else                                     rd_data <= '0;
    end
  end

  assign delay_val = delay_q;
  assign width_val = width_q;
  assign tb_ext    = tb_q;
  assign irq_src   = src_q;

endmodule

// File: rtl/pdg_core.sv
module pdg_core
  import pdg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_rise,
  input  logic             tick,
  input  logic [CNT_W-1:0] delay_val,
  input  logic [CNT_W-1:0] width_val,
  input  pdg_irq_src_e     irq_src,
  output logic             pulse_out,
  output logic             irq,
  output pdg_state_e       state
);
  pdg_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pulse_q, irq_q;
  logic             accept, dly_done, start, stop, irq_d;

  always_comb begin
    accept   = trig_rise && (st_q == ST_IDLE);
    dly_done = (st_q == ST_DELAY) && tick && (cnt_q == '0);
    start    = dly_done && (width_val != '0);
    stop     = (st_q == ST_PULSE) && tick && (cnt_q == CNT_W'(1));
    case (irq_src)
      IRQ_TRIG: irq_d = accept;
      IRQ_RISE: irq_d = start;
      IRQ_FALL: irq_d = stop;
      default:  irq_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= irq_d;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            st_q  <= ST_DELAY;
            cnt_q <= delay_val;
          end
        end
        ST_DELAY: begin
          if (tick) begin
            if (cnt_q == '0) begin
              if (width_val != '0) begin
                st_q    <= ST_PULSE;
                cnt_q   <= width_val;
                pulse_q <= 1'b1;
              end else begin
                st_q <= ST_IDLE;
              end
            end else begin
              cnt_q <= cnt_q - CNT_W'(1);
            end
          end
        end
        ST_PULSE: begin
          if (tick) begin
            if (cnt_q == CNT_W'(1)) begin
              st_q    <= ST_IDLE;
              pulse_q <= 1'b0;
            end else begin
              cnt_q <= cnt_q - CNT_W'(1);
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign pulse_out = pulse_q;
  assign irq       = irq_q;
  assign state     = st_q;

endmodule

// File: rtl/pdg_top.sv
module pdg_top
  import pdg_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              usec_tick,
  input  logic              trig_in,
  input  logic              ext_tb_in,
  output logic              pulse_out,
  output logic              irq
);
  logic [CNT_W-1:0] delay_val, width_val;
  logic             tb_ext, trig_rise, ext_rise, tick;
  pdg_irq_src_e     cfg_src;
  pdg_state_e       core_st;

  pdg_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .delay_val(delay_val),
    .width_val(width_val), .tb_ext(tb_ext), .irq_src(cfg_src)
  );

  pdg_sync_edge #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk(clk), .rst(rst), .din(trig_in), .rise(trig_rise)
  );

  pdg_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst(rst), .din(ext_tb_in), .rise(ext_rise)
  );

  assign tick = tb_ext ? ext_rise : usec_tick;

  pdg_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .trig_rise(trig_rise), .tick(tick),
    .delay_val(delay_val), .width_val(width_val), .irq_src(cfg_src),
    .pulse_out(pulse_out), .irq(irq), .state(core_st)
  );

endmodule

// File: rtl/pdg_checker.sv
module pdg_checker
  import pdg_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       pulse_out,
  input logic       irq,
  input logic [1:0] st,
  input logic [1:0] src
);

  p_rise_from_delay_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_out) |-> $past(st) == ST_DELAY);

  p_fall_to_idle_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse_out) |-> st == ST_IDLE);

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    st == ST_IDLE |-> !pulse_out);

  p_irq_rise_r8: assert property (@(posedge clk) disable iff (rst)
    (irq && $past(src) == IRQ_RISE) |-> $rose(pulse_out));

  p_irq_fall_r8: assert property (@(posedge clk) disable iff (rst)
    (irq && $past(src) == IRQ_FALL) |-> $fell(pulse_out));

  p_irq_off_r8: assert property (@(posedge clk) disable iff (rst)
    $past(src) == IRQ_NONE |-> !irq);

  p_no_retrigger_r9: assert property (@(posedge clk) disable iff (rst)
    st == ST_PULSE |=> st != ST_DELAY);

endmodule

bind pdg_top pdg_checker u_chk (
  .clk(clk), .rst(rst), .pulse_out(pulse_out), .irq(irq),
  .st(core_st), .src(cfg_src)
);

// File: tb/tb_pdg_top.sv
module tb_pdg_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;
  localparam int NVEC       = 8;

  typedef struct packed {
    logic [15:0] dly;
    logic [15:0] wid;
    logic        sel;
    logic [1:0]  src;
    logic [7:0]  rt;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{16'd0, 16'd1, 1'b0, 2'd0, 8'd0},
    '{16'd3, 16'd2, 1'b0, 2'd1, 8'd0},
    '{16'd2, 16'd3, 1'b0, 2'd2, 8'd0},
    '{16'd1, 16'd0, 1'b0, 2'd1, 8'd0},
    '{16'd2, 16'd2, 1'b1, 2'd0, 8'd0},
    '{16'd0, 16'd0, 1'b1, 2'd2, 8'd0},
    '{16'd4, 16'd3, 1'b0, 2'd3, 8'd2},
    '{16'd1, 16'd4, 1'b1, 2'd1, 8'd4}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        usec_tick = 1'b0;
  logic        trig_in = 1'b0;
  logic        ext_tb_in = 1'b0;
  logic        pulse_out, irq;

  int n_checks = 0;
  int n_fail   = 0;
  int irq_cnt  = 0;
  bit hi_seen  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdg_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .usec_tick(usec_tick),
    .trig_in(trig_in), .ext_tb_in(ext_tb_in), .pulse_out(pulse_out), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic smp();
    @(negedge clk);
    if (irq) irq_cnt++;
    if (pulse_out) hi_seen = 1;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    rd_addr = 2'(a);
    @(negedge clk);
    d = int'(rd_data);
  endtask

  task automatic ext_edge();
    ext_tb_in = 1'b1;
    repeat (3) smp();
    ext_tb_in = 1'b0;
    repeat (3) smp();
  endtask

  task automatic usec_pulse();
    usec_tick = 1'b1;
    smp();
    usec_tick = 1'b0;
    smp();
  endtask

  // One counted tick of the selected base; the other base toggles twice (R7)
  task automatic step(input logic sel);
    if (!sel) begin
      usec_pulse();
      repeat (2) ext_edge();
    end else begin
      repeat (2) usec_pulse();
      ext_edge();
    end
  endtask

  task automatic run_vec(input int idx, input vec_t v);
    int rise_s, fall_s, nsteps, exp_irq;
    string tg;
    wr(0, int'(v.dly));
    wr(1, int'(v.wid));
    wr(2, int'({v.src, v.sel}));
    irq_cnt = 0; hi_seen = 0;
    @(negedge clk);
    trig_in = 1'b1;
    smp();
    smp();
    chk($sformatf("R3 vec%0d irq early", idx), int'(irq), 0);
    smp();
    if (v.src == 2'd0) chk($sformatf("R3 vec%0d trigger irq", idx), int'(irq), 1);
    trig_in = 1'b0;
    rise_s = 0; fall_s = 0;
    nsteps = int'(v.dly) + int'(v.wid) + 3;
    for (int s = 1; s <= nsteps; s++) begin
      if (v.rt != 0 && s == int'(v.rt)) trig_in = 1'b1;
      step(v.sel);
      trig_in = 1'b0;
      if (pulse_out && rise_s == 0) rise_s = s;
      if (!pulse_out && rise_s != 0 && fall_s == 0) fall_s = s;
    end
    tg = (v.rt != 0) ? "R9" : (v.sel ? "R7" : "R4");
    if (v.wid != 0) begin
      chk($sformatf("%s vec%0d rise tick", tg, idx), rise_s, int'(v.dly) + 1);
      chk($sformatf("R5 %s vec%0d fall tick", tg, idx), fall_s,
          int'(v.dly) + int'(v.wid) + 1);
    end else begin
      chk($sformatf("R6 vec%0d no pulse", idx), int'(hi_seen), 0);
    end
    case (v.src)
      2'd0:    exp_irq = 1;
      2'd3:    exp_irq = 0;
      default: exp_irq = (v.wid != 0) ? 1 : 0;
    endcase
    chk($sformatf("R8 vec%0d irq count", idx), irq_cnt, exp_irq);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    chk("R1 pulse_out in reset", int'(pulse_out), 0);
    chk("R1 irq in reset", int'(irq), 0);
    rst = 1'b0;
    for (int a = 0; a < 4; a++) begin
      rd(a, d);
      chk($sformatf("R1 reg%0d after reset", a), d, 0);
    end

    wr(0, 16'hA5C3);
    wr(1, 16'h1234);
    wr(2, 16'hFFFF);
    rd(0, d); chk("R2 delay readback", d, 16'hA5C3);
    rd(1, d); chk("R2 width readback", d, 16'h1234);
    rd(2, d); chk("R2 ctrl readback", d, 7);
    rd(3, d); chk("R2 addr3 reads zero", d, 0);

    for (int i = 0; i < NVEC; i++) run_vec(i, VECS[i]);

    // R6: block idle again after a zero-width run, so a new trigger is taken
    run_vec(NVEC, '{16'd0, 16'd2, 1'b0, 2'd0, 8'd0});

    // R1: reset in the middle of a pulse
    wr(0, 0); wr(1, 50); wr(2, 2);
    @(negedge clk); trig_in = 1'b1;
    repeat (3) smp();
    trig_in = 1'b0;
    step(1'b0);
    chk("R1 pulse high before reset", int'(pulse_out), 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 pulse cleared by reset", int'(pulse_out), 0);
    chk("R1 irq cleared by reset", int'(irq), 0);
    rst = 1'b0;
    rd(1, d); chk("R1 width cleared by reset", d, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule